// File: doc/BRIEF.md
# Asynchronous 8080-style LCD bus bridge

The block connects an internal byte-addressed request port to a 16-bit parallel LCD bus of the 8080 kind. It drives a chip select, a write strobe, a read strobe, a register-select line and a bidirectional 16-bit data bus. Each internal request becomes exactly one asynchronous access with two phases. First comes an address-setup phase, with chip select low and both strobes high. Then comes a data phase, with one strobe low. There is no address-hold phase. The LCD reset pin is not driven by this block.

The register-select line comes from one address bit. External line 10 of a 16-bit wide device is internal byte-address bit 11. Bit 11 low addresses the command register and bit 11 high addresses the pixel/data register. Only requests whose top two address bits are 2'b11 (base 0x6C000000) reach the pins. Read accesses and write accesses take their phase lengths from two separate timing sets, so slow reads never stretch writes and nothing has to be reprogrammed between them. Each phase lasts its field value plus one clock cycles. The requester holds its request valid until a one-cycle ready pulse.

Top module: `lcd8080_bridge`

## Requirements
- R1: After reset, and while no access runs, lcd_cs_n, lcd_wr_n and lcd_rd_n are high and req_ready is low.
- R2: A request whose req_addr[27:26] is not 2'b11 causes no chip-select or strobe activity. It gets req_ready in the cycle after acceptance, and a read of this kind returns rd_data 0.
- R3: lcd_rs equals req_addr[11] of the accepted request (0 = command register, 1 = data register). It stays stable for the whole access.
- R4: A write runs cfg_wr_setup+1 cycles with lcd_cs_n low and both strobes high. It then runs cfg_wr_data+1 cycles with lcd_wr_n low and lcd_db driven with req_wdata. lcd_wr_n rises in the ready cycle.
- R5: A read runs cfg_rd_setup+1 setup cycles and then cfg_rd_data+1 cycles with lcd_rd_n low. During the read the bridge does not drive lcd_db. The two strobes are never low together.
- R6: Read data is the value on lcd_db in the last cycle of the read data phase. It is presented on rd_data while req_ready is high.
- R7: req_ready is high for exactly one cycle, the cycle right after the data phase. In that cycle chip select and both strobes are high. Chip select stays high for at least two cycles before it falls for the next access.
- R8: With cfg_wr_en low, a write produces no chip select or write strobe and gets req_ready in the cycle after acceptance. Reads still run in full.
- R9: While an access is in progress, changes to req_addr and req_wdata have no effect on the pins, and no new request is accepted before req_ready.
- R10: Write accesses use only the write timing fields and read accesses use only the read fields. This holds when both sets differ and the accesses alternate without reprogramming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Internal byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with req_ready |
| cfg_rd_setup | input | 4 | Read address-setup field |
| cfg_rd_data | input | 8 | Read data-phase field |
| cfg_wr_setup | input | 4 | Write address-setup field |
| cfg_wr_data | input | 8 | Write data-phase field |
| cfg_wr_en | input | 1 | Write enable; 0 suppresses write accesses |
| lcd_cs_n | output | 1 | LCD chip select, active low |
| lcd_wr_n | output | 1 | LCD write strobe, active low |
| lcd_rd_n | output | 1 | LCD read strobe, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_db | inout | 16 | LCD data bus |

## Verification
The bench alternates reads and writes with very different timing sets. A design that shares one counter value between the two directions, or latches the wrong set, gives phases of the wrong length. The LCD model changes its read value on every cycle of the strobe, so sampling one cycle early or late returns a different word. Accesses outside the region, and writes with the write enable off, must finish in one cycle with no chip select. A design that ignores the region decode or the enable would toggle the bus. One write changes its address and data mid-access, which exposes a bridge that does not latch the request. The extreme fields are also covered: zero-length phases and a 256-cycle read strobe.

// File: rtl/lcd8080_pkg.sv
`timescale 1ns/1ps
package lcd8080_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DATA  = 2'd2,
    ST_END   = 2'd3
  } bus_state_e;

  // register select: external line n of a 16-bit device is byte-address bit n+1
  function automatic logic addr_to_rs(input logic [31:0] a, input int unsigned ext_line);
    return a[ext_line + 1];
  endfunction

  // top two address bits pick the chip-select region
  function automatic logic addr_in_region(input logic [31:0] a, input int unsigned aw,
                                          input logic [1:0] region);
    return a[aw - 2 +: 2] == region;
  endfunction

endpackage

// File: rtl/lcd8080_decode.sv
`timescale 1ns/1ps
module lcd8080_decode #(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned RS_LINE = 10,
  parameter logic [1:0]  REGION  = 2'b11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              wr_en,
  output logic              rs,
  output logic              bypass
);
  import lcd8080_pkg::*;

  logic hit;

  assign rs     = addr_to_rs(32'(addr), RS_LINE);
  assign hit    = addr_in_region(32'(addr), ADDR_W, REGION);
  assign bypass = !hit || (is_write && !wr_en);
endmodule

// File: rtl/lcd8080_timing_sel.sv
`timescale 1ns/1ps
module lcd8080_timing_sel #(
  parameter int unsigned SETUP_W = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               is_write,
  input  logic [SETUP_W-1:0] rd_setup,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [SETUP_W-1:0] wr_setup,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [CNT_W-1:0]   setup_len,
  output logic [CNT_W-1:0]   data_len
);
  assign setup_len = is_write ? CNT_W'(wr_setup) : CNT_W'(rd_setup);
  assign data_len  = is_write ? CNT_W'(wr_data)  : CNT_W'(rd_data);
endmodule

// File: rtl/lcd8080_phase_ctr.sv
`timescale 1ns/1ps
module lcd8080_phase_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/lcd8080_bridge.sv
`timescale 1ns/1ps
module lcd8080_bridge #(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned DW      = 16,
  parameter int unsigned SETUP_W = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RS_LINE = 10,
  parameter logic [1:0]  REGION  = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [DW-1:0]     rd_data,
  input  logic [SETUP_W-1:0] cfg_rd_setup,
  input  logic [DATA_W-1:0]  cfg_rd_data,
  input  logic [SETUP_W-1:0] cfg_wr_setup,
  input  logic [DATA_W-1:0]  cfg_wr_data,
  input  logic              cfg_wr_en,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic              lcd_rs,
  inout  wire  [DW-1:0]     lcd_db
);
  import lcd8080_pkg::*;

  localparam int unsigned CNT_W = (SETUP_W > DATA_W) ? SETUP_W : DATA_W;

  bus_state_e     st;
  logic           op_write;
  logic           op_rs;
  logic [DW-1:0]  op_wdata;
  logic [DW-1:0]  rd_q;

  logic             dec_rs, dec_bypass;
  logic             sel_write;
  logic [CNT_W-1:0] setup_len, data_len, load_val;
  logic             ctr_load, ctr_zero;

  // named events for the checker
  logic accept_evt, bypass_evt, setup_done, data_done;

  assign accept_evt = (st == ST_IDLE) && req_valid;
  assign bypass_evt = accept_evt && dec_bypass;
  assign setup_done = (st == ST_SETUP) && ctr_zero;
  assign data_done  = (st == ST_DATA) && ctr_zero;

  lcd8080_decode #(.ADDR_W(ADDR_W), .RS_LINE(RS_LINE), .REGION(REGION)) u_dec (
    .addr(req_addr), .is_write(req_write), .wr_en(cfg_wr_en),
    .rs(dec_rs), .bypass(dec_bypass)
  );

  assign sel_write = (st == ST_IDLE) ? req_write : op_write;

  lcd8080_timing_sel #(.SETUP_W(SETUP_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tsel (
    .is_write(sel_write),
    .rd_setup(cfg_rd_setup), .rd_data(cfg_rd_data),
    .wr_setup(cfg_wr_setup), .wr_data(cfg_wr_data),
    .setup_len(setup_len), .data_len(data_len)
  );

  assign ctr_load = (accept_evt && !dec_bypass) || setup_done;
  assign load_val = (st == ST_IDLE) ? setup_len : data_len;

  lcd8080_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(load_val), .at_zero(ctr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_write <= 1'b0;
      op_rs    <= 1'b0;
      op_wdata <= '0;
      rd_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          op_write <= req_write;
          op_rs    <= dec_rs;
          op_wdata <= req_wdata;
          if (dec_bypass) begin
            st   <= ST_END;
            rd_q <= '0;
          end else begin
            st <= ST_SETUP;
          end
        end
        ST_SETUP: if (ctr_zero) st <= ST_DATA;
        ST_DATA: if (ctr_zero) begin
          st <= ST_END;
          if (!op_write) rd_q <= lcd_db;
        end
        ST_END: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lcd_cs_n  = !((st == ST_SETUP) || (st == ST_DATA));
  assign lcd_wr_n  = !((st == ST_DATA) && op_write);
  assign lcd_rd_n  = !((st == ST_DATA) && !op_write);
  assign lcd_rs    = op_rs;
  assign lcd_db    = ((st == ST_DATA) && op_write) ? op_wdata : {DW{1'bz}};
  assign req_ready = (st == ST_END);
  assign rd_data   = rd_q;
endmodule

// File: rtl/lcd8080_bridge_chk.sv
`timescale 1ns/1ps
module lcd8080_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic req_write,
  input logic cfg_wr_en,
  input logic req_ready,
  input logic lcd_cs_n,
  input logic lcd_wr_n,
  input logic lcd_rd_n,
  input logic lcd_rs,
  input logic accept_evt,
  input logic bypass_evt
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n));

  assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_ready_pins_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_cs_n) |-> $past(lcd_cs_n, 2));

  assert_rs_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_rs));

  assert_wr_rise_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_wr_n) |-> req_ready);

  assert_wr_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && req_write && !cfg_wr_en) |=> (lcd_cs_n && req_ready));

  assert_bypass_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_evt |=> (req_ready && lcd_cs_n));

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (lcd_cs_n && !req_ready));
endmodule

bind lcd8080_bridge lcd8080_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .cfg_wr_en(cfg_wr_en),
  .req_ready(req_ready), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
  .lcd_rd_n(lcd_rd_n), .lcd_rs(lcd_rs), .accept_evt(accept_evt),
  .bypass_evt(bypass_evt)
);

// File: tb/test_lcd8080_bridge.sv
`timescale 1ns/1ps
module test_lcd8080_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rd_data;
  logic [3:0]  rsu = 4'd1, wsu = 4'd0;
  logic [7:0]  rdp = 8'd15, wdp = 8'd3;
  logic        wen = 1'b1;
  logic        lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rs;
  wire  [15:0] lcd_db;

  int vectors = 0;
  int misses  = 0;
  string cur_tag = "R1 reset";

  // LCD model: read value advances by one each strobe cycle
  logic [15:0] rd_base = 16'h0;
  logic [15:0] rd_k = 16'h0;
  assign lcd_db = (!lcd_rd_n) ? (rd_base + rd_k) : 16'hzzzz;
  always @(posedge clk) rd_k <= (!lcd_rd_n) ? rd_k + 16'd1 : 16'd0;

  always #10 clk = ~clk;

  lcd8080_bridge i_lcd8080_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .cfg_rd_setup(rsu), .cfg_rd_data(rdp),
    .cfg_wr_setup(wsu), .cfg_wr_data(wdp), .cfg_wr_en(wen),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_rs(lcd_rs), .lcd_db(lcd_db)
  );

  typedef struct packed {
    logic        rdy, cs, wr, rd, rs, bchk;
    logic [15:0] bus;
    logic        rchk;
    logic [15:0] rdv;
  } exp_t;

  exp_t expq[$];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the expected-waveform queue
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = '{rdy:1'b0, cs:1'b1, wr:1'b1, rd:1'b1, rs:1'b0, bchk:1'b0,
                 bus:16'h0, rchk:1'b0, rdv:16'h0};
      chk("pins{ready,cs,wr,rd}", {28'h0, req_ready, lcd_cs_n, lcd_wr_n, lcd_rd_n},
          {28'h0, e.rdy, e.cs, e.wr, e.rd});
      if (!e.cs) chk("rs", {31'h0, lcd_rs}, {31'h0, e.rs});
      if (e.bchk) chk("bus", {16'h0, lcd_db}, {16'h0, e.bus});
      if (e.rchk) chk("rd_data", {16'h0, rd_data}, {16'h0, e.rdv});
    end
  end

  task automatic access(input bit wr, input logic [27:0] addr, input logic [15:0] wd,
                        input string tag, input bit mutate);
    bit hit, byp;
    int s, d;
    @(negedge clk); #1;
    cur_tag = tag;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    hit = (addr >> 26) == 28'd3;
    byp = !hit || (wr && !wen);
    if (byp) begin
      expq.push_back('{rdy:1'b1, cs:1'b1, wr:1'b1, rd:1'b1, rs:1'b0, bchk:1'b0,
                       bus:16'h0, rchk:!wr, rdv:16'h0});
    end else begin
      s = wr ? int'(wsu) : int'(rsu);
      d = wr ? int'(wdp) : int'(rdp);
      for (int i = 0; i <= s; i++)
        expq.push_back('{rdy:1'b0, cs:1'b0, wr:1'b1, rd:1'b1, rs:addr[11], bchk:1'b0,
                         bus:16'h0, rchk:1'b0, rdv:16'h0});
      for (int i = 0; i <= d; i++)
        expq.push_back('{rdy:1'b0, cs:1'b0, wr:!wr, rd:wr, rs:addr[11], bchk:wr,
                         bus:wd, rchk:1'b0, rdv:16'h0});
      expq.push_back('{rdy:1'b1, cs:1'b1, wr:1'b1, rd:1'b1, rs:1'b0, bchk:1'b0,
                       bus:16'h0, rchk:!wr, rdv:rd_base + 16'(d)});
    end
    if (mutate) begin
      @(negedge clk); #1;
      req_addr = addr ^ 28'h800;
      req_wdata = ~wd;
    end
    while (expq.size() > 0) begin
      @(negedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired in %s", cur_tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 reset pins{ready,cs,wr,rd}", {28'h0, req_ready, lcd_cs_n, lcd_wr_n, lcd_rd_n},
        32'h7);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    access(1'b1, 28'hC000000, 16'h002C, "R4 R3 write command", 1'b0);
    access(1'b1, 28'hC000800, 16'hF81F, "R4 R3 write data", 1'b0);
    rd_base = 16'h1230;
    access(1'b0, 28'hC000000, 16'h0, "R5 R6 read command", 1'b0);
    rd_base = 16'h4000;
    access(1'b0, 28'hC000800, 16'h0, "R6 R3 read data", 1'b0);
    access(1'b1, 28'hC000800, 16'h5A5A, "R10 write after read", 1'b0);
    rd_base = 16'h0700;
    access(1'b0, 28'hC000000, 16'h0, "R10 read after write", 1'b0);
    access(1'b1, 28'hC000000, 16'h1357, "R9 request changed mid-access", 1'b1);
    access(1'b1, 28'h8000800, 16'hFFFF, "R2 write outside region", 1'b0);
    access(1'b0, 28'h0000000, 16'h0, "R2 read outside region", 1'b0);
    wen = 1'b0;
    access(1'b1, 28'hC000800, 16'hBEEF, "R8 write disabled", 1'b0);
    rd_base = 16'h2200;
    access(1'b0, 28'hC000800, 16'h0, "R8 read with write disabled", 1'b0);
    wen = 1'b1;
    wsu = 4'd15; wdp = 8'd0; rsu = 4'd0; rdp = 8'd255;
    access(1'b1, 28'hC000800, 16'hA5C3, "R4 R7 long setup short data", 1'b0);
    rd_base = 16'h8000;
    access(1'b0, 28'hC000000, 16'h0, "R5 R6 longest read strobe", 1'b0);
    access(1'b1, 28'hC000000, 16'h0F0F, "R7 back-to-back write", 1'b0);
    repeat (4) @(negedge clk);
    cur_tag = "R1 idle after traffic";
    chk("R1 idle pins{ready,cs,wr,rd}", {28'h0, req_ready, lcd_cs_n, lcd_wr_n, lcd_rd_n},
        32'h7);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule